// File: doc/BRIEF.md
# Byte-Wide External Data Memory Bridge

The bridge takes one CPU data request at a time and carries it out on a narrow external memory bus. That bus has an 8-bit bidirectional data path, a 16-bit byte address, separate active-low read and write strobes, and seven active-low chip selects. The request can be 32-bit, 16-bit or 8-bit wide. The bridge splits it into byte beats and sequences them on the bus. When the last beat is complete, it pulses a completion flag. For reads, the assembled data is valid with that pulse.

Each request carries its own wait setting, from 0 to 2 extra clocks. The setting lengthens the strobe of every beat in the access. The chip select stays asserted from the first strobe to the end of the last beat. Between two beats the strobe rises for one clock. Writes send the least significant byte first and walk the address downward. Reads fetch the most significant byte first and walk the address upward. As a result, a value written with one size and base address reads back unchanged with the same size and base address. Pad drivers, and sharing select lines with general-purpose I/O, are handled outside this block.

Top module: `xmem8_bridge`

## Requirements
- R1: After reset the bridge is idle: `req_ready`=1, `done`=0, both strobes high, `mem_doe`=0 and all seven chip selects high.
- R2: Size code 0 gives one beat, code 1 gives two beats, and codes 2 and 3 give four beats. Each beat is one strobe-low run.
- R3: A read of n beats presents addresses base, base+1, …, base+n-1, wrapping at 16 bits. The byte fetched in beat k lands in byte position n-1-k of `rdata`, so the first byte is the most significant. Bytes above the access size read as zero.
- R4: A write of n beats drives byte k of `req_wdata` (bits 8k+7:8k) in beat k, at address base+n-1-k. The least significant byte goes first, and the address counts downward.
- R5: Each beat holds its strobe low for 1+W clocks and then high for one clock. W is the wait code, and code 3 behaves as 2. The address and data stay stable while the strobe is low.
- R6: Select code 0, and any code of 7 or more, drives `mem_cs_n[0]`. Codes 1 to 6 drive `mem_cs_n[code]`. Exactly that one line is low on every clock of the access, including the gaps between beats, and all lines are high while idle.
- R7: During a read only `mem_rd_n` may go low and `mem_doe` stays 0. During a write only `mem_wr_n` may go low and `mem_doe` is 1 for the whole access.
- R8: An access takes n*(2+W) clocks after acceptance. `done` is then high for exactly one clock, with `req_ready`=1 in that same clock.
- R9: While an access is in progress `req_ready` is 0 and `req_valid` is ignored. A request offered and withdrawn during that time starts no access and leaves the running one unchanged.
- R10: A write followed by a read with the same size and base address returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bridge idle; request taken when both high at a clock edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| req_addr | input | 16 | Base byte address |
| req_wdata | input | 32 | Write data |
| req_sel | input | 3 | Chip select code |
| req_wait | input | 2 | Extra strobe clocks per beat (3 treated as 2) |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Assembled read data, held until next acceptance |
| mem_addr | output | 16 | External byte address |
| mem_dout | output | 8 | Byte driven toward memory |
| mem_doe | output | 1 | Output enable for `mem_dout` |
| mem_din | input | 8 | Byte returned by memory |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_cs_n | output | 7 | Chip selects, active low; bit 0 is the fixed select |

## Verification
A wrong beat counter shows up at the ports within a single access. The access has an extra or a missing strobe-low run, and `done` arrives early or late by a multiple of 2+W clocks. A wrong address offset or lane index shows up on the first beat of a multi-byte access, as a swapped address or data byte on the bus. It also shows up at the completion pulse as a byte-permuted `rdata` or a failed round trip. A stuck wait counter changes the strobe-low length within 1+W clocks of the first strobe. A bad select register shows up as the wrong `mem_cs_n` line on the first active clock.

// File: rtl/xmem8_pkg.sv
package xmem8_pkg;

   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_STRB = 2'd1,
      XS_GAP  = 2'd2
   } xmem8_state_e;

   typedef enum logic [1:0] {
      XZ_BYTE  = 2'd0,
      XZ_HALF  = 2'd1,
      XZ_WORD  = 2'd2,
      XZ_WORD2 = 2'd3
   } xmem8_size_e;

endpackage

// File: rtl/xmem8_cs_decode.sv
module xmem8_cs_decode #(
   parameter int NUM_CS = 7,
   parameter int SEL_W  = 3
) (
   input  logic              active,
   input  logic [SEL_W-1:0]  sel,
   output logic [NUM_CS-1:0] cs_n
);
   localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(NUM_CS - 1);

   logic fixed_hit;
   assign fixed_hit = (sel == '0) || (sel > LAST_CODE);

   for (genvar g = 0; g < NUM_CS; g++) begin : g_line
      if (g == 0) begin : g_fixed
         assign cs_n[g] = ~(active & fixed_hit);
      end else begin : g_num
         assign cs_n[g] = ~(active && (sel == SEL_W'(g)));
      end
   end
endmodule

// File: rtl/xmem8_sequencer.sv
module xmem8_sequencer
   import xmem8_pkg::*;
#(
   parameter int WAIT_W = 2,
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [BEAT_W-1:0] last_idx,
   input  logic [WAIT_W-1:0] wait_cyc,
   output logic              busy,
   output logic              strobe,
   output logic              capture,
   output logic [BEAT_W-1:0] beat_idx,
   output logic              done
);
   xmem8_state_e      state_q;
   logic [WAIT_W-1:0] cnt_q;
   logic [BEAT_W-1:0] beat_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         cnt_q   <= '0;
         beat_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            XS_IDLE: begin
               if (start) begin
                  state_q <= XS_STRB;
                  cnt_q   <= '0;
                  beat_q  <= '0;
               end
            end
            XS_STRB: begin
               if (cnt_q == wait_cyc) state_q <= XS_GAP;
               else                   cnt_q   <= cnt_q + 1'b1;
            end
            XS_GAP: begin
               if (beat_q == last_idx) begin
                  state_q <= XS_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  beat_q  <= beat_q + 1'b1;
                  cnt_q   <= '0;
                  state_q <= XS_STRB;
               end
            end
            default: state_q <= XS_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != XS_IDLE);
   assign strobe   = (state_q == XS_STRB);
   assign capture  = strobe && (cnt_q == wait_cyc);
   assign beat_idx = beat_q;
   assign done     = done_q;

   // R8: one-clock completion
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (state_q == XS_IDLE));
endmodule

// File: rtl/xmem8_lane_steer.sv
module xmem8_lane_steer #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int WORD_BYTES = 4,
   parameter int BEAT_W     = 2
) (
   input  logic                         is_write,
   input  logic [ADDR_W-1:0]            base,
   input  logic [BEAT_W-1:0]            last_idx,
   input  logic [BEAT_W-1:0]            beat_idx,
   input  logic [DATA_W*WORD_BYTES-1:0] wdata,
   output logic [ADDR_W-1:0]            addr,
   output logic [DATA_W-1:0]            wbyte,
   output logic [BEAT_W-1:0]            rd_lane
);
   logic [BEAT_W-1:0] down_off;
   logic [BEAT_W-1:0] offset;
   logic [DATA_W-1:0] lanes [WORD_BYTES];

   assign down_off = last_idx - beat_idx;
   assign offset   = is_write ? down_off : beat_idx;
   assign addr     = base + ADDR_W'(offset);
   assign rd_lane  = down_off;

   for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
      assign lanes[g] = wdata[g*DATA_W +: DATA_W];
   end
   assign wbyte = lanes[beat_idx];
endmodule

// File: rtl/xmem8_bridge.sv
module xmem8_bridge
   import xmem8_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int WORD_BYTES = 4,
   parameter int NUM_CS     = 7,
   parameter int MAX_WAIT   = 2,
   localparam int WORD_W    = DATA_W * WORD_BYTES,
   localparam int SEL_W     = $clog2(NUM_CS),
   localparam int WAIT_W    = (MAX_WAIT > 0) ? $clog2(MAX_WAIT + 1) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WORD_W-1:0] req_wdata,
   input  logic [SEL_W-1:0]  req_sel,
   input  logic [WAIT_W-1:0] req_wait,
   output logic              done,
   output logic [WORD_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_doe,
   input  logic [DATA_W-1:0] mem_din,
   output logic              mem_rd_n,
   output logic              mem_wr_n,
   output logic [NUM_CS-1:0] mem_cs_n
);
   localparam int BEAT_W  = $clog2(WORD_BYTES);
   localparam int RUN_W   = WAIT_W + 1;

   if (WORD_BYTES != 4) begin : g_bad_word
      $error("xmem8_bridge: size encoding needs WORD_BYTES == 4");
   end
   if (NUM_CS < 2) begin : g_bad_cs
      $error("xmem8_bridge: NUM_CS must be at least 2");
   end
   if (MAX_WAIT < 0) begin : g_bad_wait
      $error("xmem8_bridge: MAX_WAIT must not be negative");
   end

   logic              accept;
   logic              busy, strobe, capture;
   logic [BEAT_W-1:0] beat_idx, rd_lane;
   logic [ADDR_W-1:0] steer_addr;
   logic [DATA_W-1:0] steer_byte;
   logic [WAIT_W-1:0] wait_eff;
   logic [BEAT_W-1:0] last_new;

   logic              wr_q;
   logic [ADDR_W-1:0] base_q;
   logic [WORD_W-1:0] wdata_q;
   logic [SEL_W-1:0]  sel_q;
   logic [BEAT_W-1:0] last_q;
   logic [WAIT_W-1:0] wait_q;
   logic [DATA_W-1:0] rd_lane_q [WORD_BYTES];

   assign accept = req_valid && !busy;

   if (MAX_WAIT == 0) begin : g_nowait
      assign wait_eff = '0;
   end else begin : g_wait
      assign wait_eff = (req_wait > WAIT_W'(MAX_WAIT)) ? WAIT_W'(MAX_WAIT) : req_wait;
   end

   always_comb begin
      unique case (xmem8_size_e'(req_size))
         XZ_BYTE: last_new = BEAT_W'(0);
         XZ_HALF: last_new = BEAT_W'(1);
         default: last_new = BEAT_W'(WORD_BYTES - 1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         base_q  <= '0;
         wdata_q <= '0;
         sel_q   <= '0;
         last_q  <= '0;
         wait_q  <= '0;
      end else if (accept) begin
         wr_q    <= req_write;
         base_q  <= req_addr;
         wdata_q <= req_wdata;
         sel_q   <= req_sel;
         last_q  <= last_new;
         wait_q  <= wait_eff;
      end
   end

   xmem8_sequencer #(.WAIT_W(WAIT_W), .BEAT_W(BEAT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .last_idx (last_q),
      .wait_cyc (wait_q),
      .busy     (busy),
      .strobe   (strobe),
      .capture  (capture),
      .beat_idx (beat_idx),
      .done     (done)
   );

   xmem8_lane_steer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES), .BEAT_W(BEAT_W)
   ) u_steer (
      .is_write (wr_q),
      .base     (base_q),
      .last_idx (last_q),
      .beat_idx (beat_idx),
      .wdata    (wdata_q),
      .addr     (steer_addr),
      .wbyte    (steer_byte),
      .rd_lane  (rd_lane)
   );

   xmem8_cs_decode #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cs (
      .active (busy),
      .sel    (sel_q),
      .cs_n   (mem_cs_n)
   );

   for (genvar g = 0; g < WORD_BYTES; g++) begin : g_rlane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                       rd_lane_q[g] <= '0;
         else if (accept)                                  rd_lane_q[g] <= '0;
         else if (capture && !wr_q && rd_lane == BEAT_W'(g)) rd_lane_q[g] <= mem_din;
      end
      assign rdata[g*DATA_W +: DATA_W] = rd_lane_q[g];
   end

   assign req_ready = !busy;
   assign mem_rd_n  = !(strobe && !wr_q);
   assign mem_wr_n  = !(strobe && wr_q);
   assign mem_doe   = busy && wr_q;
   assign mem_addr  = busy ? steer_addr : '0;
   assign mem_dout  = (busy && wr_q) ? steer_byte : '0;

   // strobe-low run length, kept only for the wait bound check
   logic [RUN_W-1:0] strb_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         strb_run_q <= '0;
      else if (mem_rd_n && mem_wr_n)      strb_run_q <= '0;
      else if (strb_run_q != '1)          strb_run_q <= strb_run_q + 1'b1;
   end

   a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_rd_n && !mem_wr_n));
   a_r6_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rd_n || !mem_wr_n) |-> ($countones(~mem_cs_n) == 1));
   a_r6_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $past(!req_ready)) |-> $stable(mem_cs_n));
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r5_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
      strb_run_q <= RUN_W'(MAX_WAIT + 1));
   a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!(mem_rd_n && mem_wr_n) && $past(!(mem_rd_n && mem_wr_n))) |-> $stable(mem_addr));
   a_r7_oe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_wr_n |-> mem_doe);
   a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_n && mem_wr_n) |-> !req_ready);
endmodule

// File: tb/sim_xmem8_bridge.sv
module sim_xmem8_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [15:0] req_addr = 16'd0;
   logic [31:0] req_wdata = 32'd0;
   logic [2:0]  req_sel = 3'd0;
   logic [1:0]  req_wait = 2'd0;
   logic        done;
   logic [31:0] rdata;
   logic [15:0] mem_addr;
   logic [7:0]  mem_dout;
   logic        mem_doe;
   logic [7:0]  mem_din;
   logic        mem_rd_n, mem_wr_n;
   logic [6:0]  mem_cs_n;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [7:0] mem   [256];
   logic [7:0] model [256];

   always #2 clk = ~clk;   // 250 MHz

   xmem8_bridge u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_sel(req_sel), .req_wait(req_wait),
      .done(done), .rdata(rdata), .mem_addr(mem_addr), .mem_dout(mem_dout),
      .mem_doe(mem_doe), .mem_din(mem_din), .mem_rd_n(mem_rd_n),
      .mem_wr_n(mem_wr_n), .mem_cs_n(mem_cs_n)
   );

   assign mem_din = mem[mem_addr[7:0]];
   always @(posedge clk) if (!mem_wr_n && mem_doe) mem[mem_addr[7:0]] <= mem_dout;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int beats_of(input logic [1:0] sz);
      return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
   endfunction

   function automatic logic [6:0] cs_of(input logic [2:0] s);
      if (s == 3'd0 || s == 3'd7) return 7'b1111110;
      return ~(7'b1 << s);
   endfunction

   task automatic access(input bit w, input logic [1:0] sz, input logic [15:0] base,
                         input logic [31:0] wd, input logic [2:0] sel, input logic [1:0] wt,
                         input bit poke, output logic [31:0] rd);
      int n, we, cyc, beats, slow, bad_cs, bad_dir, bad_rdy;
      bit prev;
      logic [15:0] a_seen [4];
      logic [7:0]  d_seen [4];
      logic [31:0] exp_rd;
      n  = beats_of(sz);
      we = (wt == 2'd3) ? 2 : int'(wt);
      @(negedge clk);
      chk(req_ready == 1'b1, "R9 ready before request", 32'(req_ready), 32'd1);
      req_write = w; req_size = sz; req_addr = base; req_wdata = wd;
      req_sel = sel; req_wait = wt; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1; beats = 0; slow = 0; bad_cs = 0; bad_dir = 0; bad_rdy = 0; prev = 1'b0;
      while (!done && cyc < 64) begin
         bit s;
         s = !mem_rd_n || !mem_wr_n;
         if (s) begin
            slow++;
            if (!prev && beats < 4) begin
               a_seen[beats] = mem_addr;
               d_seen[beats] = mem_dout;
            end
            if (!prev) beats++;
         end
         if (mem_cs_n != cs_of(sel)) bad_cs++;
         if (w ? (!mem_rd_n || !mem_doe) : (!mem_wr_n || mem_doe)) bad_dir++;
         if (req_ready) bad_rdy++;
         if (poke && cyc == 2) begin
            req_valid = 1'b1; req_write = ~w; req_addr = base ^ 16'h0F0F; req_sel = sel ^ 3'd5;
         end
         if (poke && cyc == 3) req_valid = 1'b0;
         prev = s;
         @(negedge clk);
         cyc++;
      end
      chk(cyc == n*(2+we)+1, "R8 access length", 32'(cyc), 32'(n*(2+we)+1));
      chk(req_ready == 1'b1, "R8 ready with done", 32'(req_ready), 32'd1);
      chk(beats == n, "R2 beat count", 32'(beats), 32'(n));
      chk(slow == n*(1+we), "R5 strobe-low clocks", 32'(slow), 32'(n*(1+we)));
      chk(bad_cs == 0, "R6 chip select", 32'(bad_cs), 32'd0);
      chk(bad_dir == 0, "R7 direction", 32'(bad_dir), 32'd0);
      chk(bad_rdy == 0, "R9 ready low while busy", 32'(bad_rdy), 32'd0);
      for (int k = 0; k < n && k < beats; k++) begin
         logic [15:0] ea;
         ea = w ? (base + 16'(n-1-k)) : (base + 16'(k));
         chk(a_seen[k] == ea, w ? "R4 write address" : "R3 read address", 32'(a_seen[k]), 32'(ea));
         if (w) chk(d_seen[k] == wd[8*k +: 8], "R4 write byte", 32'(d_seen[k]), 32'(wd[8*k +: 8]));
      end
      exp_rd = 32'd0;
      if (w) begin
         for (int j = 0; j < n; j++) model[8'(base + 16'(n-1-j))] = wd[8*j +: 8];
      end else begin
         for (int k = 0; k < n; k++) exp_rd = (exp_rd << 8) | 32'(model[8'(base + 16'(k))]);
      end
      chk(rdata == exp_rd, "R3 read data", rdata, exp_rd);
      rd = rdata;
      if (poke) begin
         int idle_bad;
         idle_bad = 0;
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!mem_rd_n || !mem_wr_n || mem_cs_n != 7'h7F) idle_bad++;
         end
         chk(idle_bad == 0, "R9 withdrawn request ignored", 32'(idle_bad), 32'd0);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] r, v;
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 256; i++) begin
         mem[i]   = 8'($urandom);
         model[i] = mem[i];
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1 && done == 1'b0, "R1 reset handshake", {30'd0, req_ready, done}, 32'h2);
      chk(mem_rd_n && mem_wr_n && !mem_doe, "R1 reset strobes", {29'd0, mem_rd_n, mem_wr_n, mem_doe}, 32'h6);
      chk(mem_cs_n == 7'h7F, "R1 reset selects", 32'(mem_cs_n), 32'h7F);
      rst_n = 1'b1;
      @(negedge clk);

      // directed: every size, direction, wait and select
      for (int s = 0; s < 4; s++)
         for (int wt = 0; wt < 4; wt++) begin
            access(1'b1, 2'(s), 16'h0040 + 16'(s*8), 32'hA1B2C3D4 ^ 32'(wt), 3'(s+wt), 2'(wt), 1'b0, r);
            access(1'b0, 2'(s), 16'h0040 + 16'(s*8), 32'd0, 3'(7-s-wt), 2'(wt), 1'b0, r);
         end
      // R3 address wrap at 16 bits
      access(1'b0, 2'd2, 16'hFFFE, 32'd0, 3'd6, 2'd1, 1'b0, r);
      // R9 request offered while busy
      access(1'b0, 2'd2, 16'h0080, 32'd0, 3'd2, 2'd2, 1'b1, r);
      access(1'b1, 2'd1, 16'h0090, 32'h0000BEEF, 3'd1, 2'd0, 1'b1, r);

      // random round trips (R10)
      for (int i = 0; i < 60; i++) begin
         logic [1:0]  sz;
         logic [15:0] a;
         logic [31:0] wdv, mask;
         logic [2:0]  sl;
         sz  = 2'($urandom_range(0, 3));
         a   = 16'($urandom);
         wdv = $urandom;
         sl  = 3'($urandom_range(0, 7));
         mask = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFFFFFF;
         access(1'b1, sz, a, wdv, sl, 2'($urandom_range(0, 3)), 1'b0, r);
         access(1'b0, sz, a, 32'd0, sl, 2'($urandom_range(0, 3)), 1'b0, v);
         chk(v == (wdv & mask), "R10 round trip", v, wdv & mask);
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule